// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block sits between a CPU and a flash programming engine. The CPU writes an 8-bit control register. That write holds an interrupt-enable bit and a group of command bits. A valid write arms one command. A store strobe that arrives inside a short window then issues that command to the engine as a one-cycle command pulse, with a page address, a word address and a data word. The commands are page-buffer word load, page erase, page write, lock-byte set and read-section re-enable.

If no strobe arrives in time, the armed bits drop back to zero. Erase and write stay pending until the engine reports completion, and the enable bit stays high while they are pending. Pages below a configurable boundary form the section that the CPU may keep reading while the rest of the flash is programmed. Erasing or writing one of those pages raises a busy flag that blocks reads of that section. After the CPU arms a lock-set, a load strobe that follows soon enough returns the lock byte or the fuse byte in place of a normal read. A ready interrupt request is raised while the controller is idle and interrupts are enabled.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: After a synchronous reset, the register reads 0x00, and `cmd_valid`, `buf_clear`, `cfg_rd_valid` and `irq` are all low.
- R2: Register bit 5 always reads 0. Bit 6 (busy) cannot be changed by a register write.
- R3: Every register write updates bit 7 (interrupt enable). Bits 4..0 change only when the written value is one of 00001 (load), 00011 (erase), 00101 (write), 01001 (lock set) or 10001 (re-enable). Any other value leaves them unchanged.
- R4: An arming write at clock edge E0 lets a store strobe issue a command when it is sampled at any of the edges E1..E4. If no strobe arrives, bits 4..0 read 0 after E4 and a later strobe issues nothing.
- R5: A load issues `cmd_op`=1 with `cmd_page`=Z[ZW-1:WB+1], `cmd_word`=Z[WB:1] and `cmd_data`= the data word. Z[0] is ignored, and bits 4..0 clear at the issue edge.
- R6: Erase (`cmd_op`=2) and write (`cmd_op`=3) carry the page taken from the upper part of Z, with `cmd_data`=0 and `cmd_word`=0. Bits 0 and 1 (erase) or bits 0 and 2 (write) stay set past the window until `eng_done`, and then clear.
- R7: Busy (bit 6) is set when an erase or write targets a page number below RWW_PAGES. It stays unchanged for higher pages.
- R8: Busy is cleared by an issued re-enable (`cmd_op`=5) or by an issued load.
- R9: A re-enable issued while buffer words have been loaded since the last write or re-enable pulses `buf_clear` together with `cmd_valid`. Otherwise `buf_clear` stays low.
- R10: Lock set issues `cmd_op`=4 with `cmd_data` = {8'h00, low data byte}, `cmd_page`=0 and `cmd_word`=0.
- R11: A load strobe sampled at E1..E3 after a lock-set arming write at E0 gives `cfg_rd_valid`=1 on the next cycle. `cfg_rd_data` is the lock byte when Z[0]=0 and the fuse byte when Z[0]=1. At E4 or later, or with nothing armed, there is no response.
- R12: `irq` is high exactly when bit 7, `global_ie` and NOT bit 0 all hold.
- R13: While an erase or write is pending, register writes change only bit 7 and store strobes issue nothing.
- R14: A store strobe with nothing armed issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write value |
| reg_rd_data | output | 8 | Register read value |
| global_ie | input | 1 | CPU global interrupt flag |
| irq | output | 1 | Ready interrupt request |
| store_strobe | input | 1 | Store-program strobe |
| load_strobe | input | 1 | Load-program-memory strobe |
| z_ptr | input | ZW | Z pointer address |
| data_word | input | 16 | Data word for buffer load or lock set |
| eng_done | input | 1 | Engine completion pulse for erase or write |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_op | output | 3 | Command code (1 load, 2 erase, 3 write, 4 lock, 5 re-enable) |
| cmd_page | output | ZW-1-WB | Page address |
| cmd_word | output | WB | Word address inside the page |
| cmd_data | output | 16 | Command data |
| buf_clear | output | 1 | Discard page buffer contents |
| lock_bits | input | CFGW | Current lock byte |
| fuse_bits | input | CFGW | Current fuse byte |
| cfg_rd_valid | output | 1 | Lock or fuse read response valid |
| cfg_rd_data | output | CFGW | Lock or fuse read response |

## Verification
The bench builds the block with a 12-bit Z pointer, 8-word pages and a boundary of 192 pages. With these values the page field is 8 bits and the word field is 3 bits. Pages 191 and 192, on either side of the busy boundary, can then be reached with small Z values, and the split between page, word and the ignored Z[0] is easy to see in the expected items. The window keeps its default of four cycles, so the first and last accepted strobe edges and the first rejected edge are all exercised.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_ERASE = 3'd2,
        OP_WRITE = 3'd3,
        OP_LOCK  = 3'd4,
        OP_REEN  = 3'd5
    } fsp_op_e;

    localparam int unsigned BIT_IE   = 7;
    localparam int unsigned BIT_BUSY = 6;

    localparam logic [4:0] PAT_LOAD  = 5'b00001;
    localparam logic [4:0] PAT_ERASE = 5'b00011;
    localparam logic [4:0] PAT_WRITE = 5'b00101;
    localparam logic [4:0] PAT_LOCK  = 5'b01001;
    localparam logic [4:0] PAT_REEN  = 5'b10001;

    typedef struct packed {
        logic    ie;
        logic    busy;
        fsp_op_e armed;
    } fsp_state_t;

    function automatic fsp_op_e decode_arm(input logic [4:0] low);
        fsp_op_e r;
        case (low)
            PAT_LOAD:  r = OP_LOAD;
            PAT_ERASE: r = OP_ERASE;
            PAT_WRITE: r = OP_WRITE;
            PAT_LOCK:  r = OP_LOCK;
            PAT_REEN:  r = OP_REEN;
            default:   r = OP_NONE;
        endcase
        return r;
    endfunction

    function automatic logic [4:0] op_to_low(input fsp_op_e op);
        logic [4:0] r;
        case (op)
            OP_LOAD:  r = PAT_LOAD;
            OP_ERASE: r = PAT_ERASE;
            OP_WRITE: r = PAT_WRITE;
            OP_LOCK:  r = PAT_LOCK;
            OP_REEN:  r = PAT_REEN;
            default:  r = 5'b00000;
        endcase
        return r;
    endfunction

    function automatic logic is_long_op(input fsp_op_e op);
        return (op == OP_ERASE) || (op == OP_WRITE);
    endfunction

endpackage

// File: rtl/fsp_arm_timer.sv
module fsp_arm_timer #(
    parameter int unsigned WIN_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic running,
    input  logic consume,
    output logic expire,
    output logic window_open
);
    localparam int unsigned CW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(WIN_CYCLES - 1);

    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (arm) begin
            count <= LOAD;
        end else if (consume) begin
            count <= '0;
        end else if (running && count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign expire      = running && !consume && !arm && (count == '0);
    assign window_open = (count != '0);

endmodule

// File: rtl/fsp_cfg_read.sv
module fsp_cfg_read #(
    parameter int unsigned CFGW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_strobe,
    input  logic            lock_armed,
    input  logic            window_open,
    input  logic            sel_fuse,
    input  logic [CFGW-1:0] lock_bits,
    input  logic [CFGW-1:0] fuse_bits,
    output logic            rd_valid,
    output logic [CFGW-1:0] rd_data
);
    logic hit;
    assign hit = load_strobe && lock_armed && window_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= hit;
            if (hit) begin
                rd_data <= sel_fuse ? fuse_bits : lock_bits;
            end
        end
    end

endmodule

// File: rtl/fsp_cmd_core.sv
module fsp_cmd_core
    import fsp_pkg::*;
#(
    parameter int unsigned ZW        = 16,
    parameter int unsigned WB        = 5,
    parameter int unsigned PGW       = 10,
    parameter int unsigned RWW_PAGES = 896
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            wr_ie,
    input  logic [4:0]      wr_low,
    input  logic            store_strobe,
    input  logic [ZW-2:0]   z_hi,
    input  logic [15:0]     din,
    input  logic            eng_done,
    input  logic            expire,
    output fsp_state_t      st,
    output logic            op_active,
    output logic            take,
    output logic            arm_pulse,
    output logic            cmd_valid,
    output fsp_op_e         cmd_op,
    output logic [PGW-1:0]  cmd_page,
    output logic [WB-1:0]   cmd_word,
    output logic [15:0]     cmd_data,
    output logic            buf_clear
);
    fsp_op_e        wr_op;
    logic [PGW-1:0] z_page;
    logic [WB-1:0]  z_word;
    logic           page_in_rww;
    logic           buf_loaded;

    assign wr_op       = decode_arm(wr_low);
    assign z_page      = z_hi[ZW-2:WB];
    assign z_word      = z_hi[WB-1:0];
    assign page_in_rww = (32'(z_page) < RWW_PAGES);

    assign take      = store_strobe && (st.armed != OP_NONE) && !op_active;
    assign arm_pulse = wr_en && (wr_op != OP_NONE) && !op_active && !take;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= '{ie: 1'b0, busy: 1'b0, armed: OP_NONE};
            op_active  <= 1'b0;
            buf_loaded <= 1'b0;
            cmd_valid  <= 1'b0;
            cmd_op     <= OP_NONE;
            cmd_page   <= '0;
            cmd_word   <= '0;
            cmd_data   <= '0;
            buf_clear  <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            buf_clear <= 1'b0;
            if (wr_en) begin
                st.ie <= wr_ie;
            end
            if (take) begin
                cmd_valid <= 1'b1;
                cmd_op    <= st.armed;
                cmd_page  <= '0;
                cmd_word  <= '0;
                cmd_data  <= '0;
                unique case (st.armed)
                    OP_LOAD: begin
                        cmd_page   <= z_page;
                        cmd_word   <= z_word;
                        cmd_data   <= din;
                        st.busy    <= 1'b0;
                        buf_loaded <= 1'b1;
                        st.armed   <= OP_NONE;
                    end
                    OP_ERASE, OP_WRITE: begin
                        cmd_page  <= z_page;
                        op_active <= 1'b1;
                        if (page_in_rww) begin
                            st.busy <= 1'b1;
                        end
                        if (st.armed == OP_WRITE) begin
                            buf_loaded <= 1'b0;
                        end
                    end
                    OP_LOCK: begin
                        cmd_data <= {8'h00, din[7:0]};
                        st.armed <= OP_NONE;
                    end
                    OP_REEN: begin
                        st.busy    <= 1'b0;
                        buf_clear  <= buf_loaded;
                        buf_loaded <= 1'b0;
                        st.armed   <= OP_NONE;
                    end
                    default: begin
                        st.armed <= OP_NONE;
                    end
                endcase
            end else if (arm_pulse) begin
                st.armed <= wr_op;
            end else if (op_active && eng_done) begin
                op_active <= 1'b0;
                st.armed  <= OP_NONE;
            end else if (expire) begin
                st.armed <= OP_NONE;
            end
        end
    end

endmodule

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl
    import fsp_pkg::*;
#(
    parameter int unsigned ZW         = 16,
    parameter int unsigned PAGE_WORDS = 32,
    parameter int unsigned RWW_PAGES  = 896,
    parameter int unsigned WIN_CYCLES = 4,
    parameter int unsigned CFGW       = 8,
    localparam int unsigned WB        = $clog2(PAGE_WORDS),
    localparam int unsigned PGW       = ZW - 1 - WB
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr_en,
    input  logic [7:0]      reg_wr_data,
    output logic [7:0]      reg_rd_data,
    input  logic            global_ie,
    output logic            irq,
    input  logic            store_strobe,
    input  logic            load_strobe,
    input  logic [ZW-1:0]   z_ptr,
    input  logic [15:0]     data_word,
    input  logic            eng_done,
    output logic            cmd_valid,
    output logic [2:0]      cmd_op,
    output logic [PGW-1:0]  cmd_page,
    output logic [WB-1:0]   cmd_word,
    output logic [15:0]     cmd_data,
    output logic            buf_clear,
    input  logic [CFGW-1:0] lock_bits,
    input  logic [CFGW-1:0] fuse_bits,
    output logic            cfg_rd_valid,
    output logic [CFGW-1:0] cfg_rd_data
);
    fsp_state_t st;
    fsp_op_e    cmd_op_q;
    logic       op_active;
    logic       take;
    logic       arm_pulse;
    logic       expire;
    logic       window_open;
    logic       unused_wr_bits;

    assign unused_wr_bits = ^reg_wr_data[6:5];

    fsp_cmd_core #(
        .ZW        (ZW),
        .WB        (WB),
        .PGW       (PGW),
        .RWW_PAGES (RWW_PAGES)
    ) core_i (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (reg_wr_en),
        .wr_ie        (reg_wr_data[BIT_IE]),
        .wr_low       (reg_wr_data[4:0]),
        .store_strobe (store_strobe),
        .z_hi         (z_ptr[ZW-1:1]),
        .din          (data_word),
        .eng_done     (eng_done),
        .expire       (expire),
        .st           (st),
        .op_active    (op_active),
        .take         (take),
        .arm_pulse    (arm_pulse),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op_q),
        .cmd_page     (cmd_page),
        .cmd_word     (cmd_word),
        .cmd_data     (cmd_data),
        .buf_clear    (buf_clear)
    );

    fsp_arm_timer #(
        .WIN_CYCLES (WIN_CYCLES)
    ) timer_i (
        .clk         (clk),
        .rst         (rst),
        .arm         (arm_pulse),
        .running     ((st.armed != OP_NONE) && !op_active),
        .consume     (take),
        .expire      (expire),
        .window_open (window_open)
    );

    fsp_cfg_read #(
        .CFGW (CFGW)
    ) cfg_i (
        .clk         (clk),
        .rst         (rst),
        .load_strobe (load_strobe),
        .lock_armed  (st.armed == OP_LOCK),
        .window_open (window_open),
        .sel_fuse    (z_ptr[0]),
        .lock_bits   (lock_bits),
        .fuse_bits   (fuse_bits),
        .rd_valid    (cfg_rd_valid),
        .rd_data     (cfg_rd_data)
    );

    assign cmd_op      = cmd_op_q;
    assign reg_rd_data = {st.ie, st.busy, 1'b0, op_to_low(st.armed)};
    assign irq         = st.ie && global_ie && (st.armed == OP_NONE);

endmodule

// File: rtl/fsp_ctrl_chk.sv
module fsp_ctrl_chk #(
    parameter int unsigned PGW       = 10,
    parameter int unsigned RWW_PAGES = 896
) (
    input logic           clk,
    input logic           rst,
    input logic           en_bit,
    input logic           busy_bit,
    input logic           store_strobe,
    input logic           load_strobe,
    input logic           cmd_valid,
    input logic [2:0]     cmd_op,
    input logic [PGW-1:0] cmd_page,
    input logic           buf_clear,
    input logic           cfg_rd_valid
);
    // R14
    unarmed_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (store_strobe && !en_bit) |=> !cmd_valid);

    // R6
    prog_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd3)) |-> en_bit);

    // R9
    clear_needs_reen_chk: assert property (@(posedge clk) disable iff (rst)
        buf_clear |-> (cmd_valid && cmd_op == 3'd5));

    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_bit) |-> (cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd3)
                             && (32'(cmd_page) < RWW_PAGES)));

    // R8
    load_clears_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd1) |-> !busy_bit);

    // R11
    cfg_read_src_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_rd_valid |-> $past(load_strobe));

endmodule

bind flash_selfprog_ctrl fsp_ctrl_chk #(
    .PGW       (PGW),
    .RWW_PAGES (RWW_PAGES)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .en_bit       (reg_rd_data[0]),
    .busy_bit     (reg_rd_data[6]),
    .store_strobe (store_strobe),
    .load_strobe  (load_strobe),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_page     (cmd_page),
    .buf_clear    (buf_clear),
    .cfg_rd_valid (cfg_rd_valid)
);

// File: tb/flash_selfprog_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_selfprog_ctrl_tb_top;
    localparam int unsigned ZW = 12;
    localparam int unsigned PW = 8;
    localparam int unsigned WW = 3;

    typedef struct packed {
        logic [2:0]    op;
        logic [PW-1:0] page;
        logic [WW-1:0] word;
        logic [15:0]   data;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr_en = 1'b0;
    logic [7:0]    reg_wr_data = '0;
    logic [7:0]    reg_rd_data;
    logic          global_ie = 1'b0;
    logic          irq;
    logic          store_strobe = 1'b0;
    logic          load_strobe = 1'b0;
    logic [ZW-1:0] z_ptr = '0;
    logic [15:0]   data_word = '0;
    logic          eng_done = 1'b0;
    logic          cmd_valid;
    logic [2:0]    cmd_op;
    logic [PW-1:0] cmd_page;
    logic [WW-1:0] cmd_word;
    logic [15:0]   cmd_data;
    logic          buf_clear;
    logic [7:0]    lock_bits = 8'h3C;
    logic [7:0]    fuse_bits = 8'hE2;
    logic          cfg_rd_valid;
    logic [7:0]    cfg_rd_data;

    int   n_checks = 0;
    int   n_err    = 0;
    exp_t exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    flash_selfprog_ctrl #(
        .ZW(ZW), .PAGE_WORDS(8), .RWW_PAGES(192), .WIN_CYCLES(4), .CFGW(8)
    ) dut_i (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .global_ie(global_ie), .irq(irq),
        .store_strobe(store_strobe), .load_strobe(load_strobe), .z_ptr(z_ptr),
        .data_word(data_word), .eng_done(eng_done), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_page(cmd_page), .cmd_word(cmd_word),
        .cmd_data(cmd_data), .buf_clear(buf_clear), .lock_bits(lock_bits),
        .fuse_bits(fuse_bits), .cfg_rd_valid(cfg_rd_valid), .cfg_rd_data(cfg_rd_data)
    );

    function automatic exp_t mk(input logic [2:0] op, input logic [PW-1:0] pg,
                                input logic [WW-1:0] wd, input logic [15:0] dt);
        return '{op: op, page: pg, word: wd, data: dt};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: pops one expected item per issued command.
    always @(negedge clk) begin
        if (!rst && cmd_valid) begin
            exp_t  got;
            exp_t  want;
            string t;
            got = mk(cmd_op, cmd_page, cmd_word, cmd_data);
            n_checks++;
            if (exp_q.size() == 0) begin
                n_err++;
                $display("FAIL R14 unexpected command: actual %h expected none", got);
            end else begin
                want = exp_q.pop_front();
                t    = tag_q.pop_front();
                if (got !== want) begin
                    n_err++;
                    $display("FAIL %s command: actual %h expected %h", t, got, want);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [7:0] v);
        reg_wr_en = 1'b1;
        reg_wr_data = v;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic fire(input logic [ZW-1:0] z, input logic [15:0] d,
                        input logic want, input exp_t e, input string tag);
        if (want) begin
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        store_strobe = 1'b1;
        z_ptr = z;
        data_word = d;
        tick();
        store_strobe = 1'b0;
        if (want) chk({tag, " issued"}, exp_q.size(), 0);
        else      chk({tag, " no command"}, cmd_valid, 0);
    endtask

    task automatic cfg_load(input logic [ZW-1:0] z);
        load_strobe = 1'b1;
        z_ptr = z;
        tick();
        load_strobe = 1'b0;
    endtask

    task automatic done_pulse();
        eng_done = 1'b1;
        tick();
        eng_done = 1'b0;
    endtask

    initial begin
        #250000;
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 reg", reg_rd_data, 8'h00);
        chk("R1 cmd_valid", cmd_valid, 0);
        chk("R1 buf_clear", buf_clear, 0);
        chk("R1 cfg_rd_valid", cfg_rd_valid, 0);
        chk("R1 irq", irq, 0);

        // R2 R3: invalid low pattern, ie written, bits 6/5 not writable
        wr(8'hFF);
        chk("R3 invalid pattern ignored", reg_rd_data, 8'h80);
        chk("R2 reserved and busy", reg_rd_data[6:5], 2'b00);
        wr(8'h60);
        chk("R2 write to bits 6/5", reg_rd_data, 8'h00);
        wr(8'h80);
        global_ie = 1'b1;
        tick();
        chk("R12 irq idle", irq, 1);

        // R4 expiry
        wr(8'h83);
        chk("R3 erase armed", reg_rd_data, 8'h83);
        chk("R12 irq low while armed", irq, 0);
        idle(3);
        chk("R4 still armed at E3", reg_rd_data, 8'h83);
        tick();
        chk("R4 expired after E4", reg_rd_data, 8'h80);
        fire(12'h050, 16'h0, 1'b0, mk(0, 0, 0, 0), "R14 strobe after expiry");

        // R5 load, Z[0] ignored
        wr(8'h81);
        fire(12'h235, 16'hBEEF, 1'b1, mk(3'd1, 8'h23, 3'd2, 16'hBEEF), "R5 load");
        chk("R5 enable cleared", reg_rd_data, 8'h80);
        // R4 last accepted edge
        wr(8'h81);
        idle(3);
        fire(12'h23E, 16'h1357, 1'b1, mk(3'd1, 8'h23, 3'd7, 16'h1357), "R4 strobe at E4");

        // R6 R7 erase inside the read-while-write section
        wr(8'h83);
        fire(12'hBF0, 16'h1234, 1'b1, mk(3'd2, 8'hBF, 3'd0, 16'h0), "R6 erase page 191");
        chk("R7 busy set", reg_rd_data, 8'hC3);
        idle(6);
        chk("R6 held pending", reg_rd_data, 8'hC3);
        chk("R12 irq low while pending", irq, 0);
        // R13 writes and strobes ignored while pending
        wr(8'h11);
        chk("R13 write during op", reg_rd_data, 8'h43);
        wr(8'h91);
        chk("R13 re-enable during op", reg_rd_data, 8'hC3);
        fire(12'h000, 16'h0, 1'b0, mk(0, 0, 0, 0), "R13 strobe during op");
        done_pulse();
        chk("R6 cleared on done", reg_rd_data, 8'hC0);
        chk("R12 irq after done", irq, 1);

        // R8 R9 re-enable with buffered data
        wr(8'h91);
        chk("R3 re-enable armed", reg_rd_data, 8'hD1);
        fire(12'h000, 16'h0, 1'b1, mk(3'd5, 0, 0, 0), "R8 re-enable");
        chk("R9 buf_clear with data", buf_clear, 1);
        chk("R8 busy cleared", reg_rd_data, 8'h80);
        wr(8'h91);
        fire(12'h000, 16'h0, 1'b1, mk(3'd5, 0, 0, 0), "R9 re-enable empty");
        chk("R9 no buf_clear when empty", buf_clear, 0);

        // R7 write outside the section
        wr(8'h85);
        fire(12'hC00, 16'hFFFF, 1'b1, mk(3'd3, 8'hC0, 3'd0, 16'h0), "R6 write page 192");
        chk("R7 no busy at page 192", reg_rd_data, 8'h85);
        done_pulse();
        chk("R6 write done", reg_rd_data, 8'h80);

        // R8 load clears busy
        wr(8'h83);
        fire(12'h050, 16'h0, 1'b1, mk(3'd2, 8'h05, 3'd0, 16'h0), "R7 erase page 5");
        done_pulse();
        chk("R7 busy after page 5", reg_rd_data, 8'hC0);
        wr(8'h81);
        fire(12'h012, 16'h0F0F, 1'b1, mk(3'd1, 8'h01, 3'd1, 16'h0F0F), "R8 load");
        chk("R8 busy cleared by load", reg_rd_data, 8'h80);

        // R10 lock set
        wr(8'h89);
        chk("R3 lock armed", reg_rd_data, 8'h89);
        fire(12'hFFF, 16'hA55A, 1'b1, mk(3'd4, 0, 0, 16'h005A), "R10 lock set");
        chk("R10 cleared", reg_rd_data, 8'h80);

        // R11 lock/fuse read
        wr(8'h89);
        idle(2);
        cfg_load(12'h000);
        chk("R11 lock read valid at E3", cfg_rd_valid, 1);
        chk("R11 lock byte", cfg_rd_data, 8'h3C);
        idle(3);
        wr(8'h89);
        cfg_load(12'h001);
        chk("R11 fuse read valid at E1", cfg_rd_valid, 1);
        chk("R11 fuse byte", cfg_rd_data, 8'hE2);
        idle(4);
        wr(8'h89);
        idle(3);
        cfg_load(12'h000);
        chk("R11 no read at E4", cfg_rd_valid, 0);
        cfg_load(12'h000);
        chk("R11 no read unarmed", cfg_rd_valid, 0);

        idle(4);
        chk("R5 scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule